// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K words by 16 bits. The host asks for one word at a time with a request, a write flag, a 17-bit address, write data and a per-byte enable mask. The controller turns each request into the RAM's active-low chip-enable, output-enable, write-enable and per-byte select strobes. It drives the shared data bus through a separate output-enable, and the pad-level tri-state buffer is left to the level above. Every strobe is registered, so the RAM pins never glitch.

Each minimum timing of the RAM is a parameter given in clock cycles: read wait states, write setup, write strobe width and bus turnaround. A write lowers chip-enable and write-enable first with both byte selects high. The byte selects then frame the actual write, so a write always ends on a byte-select edge, while data, address and write-enable are still held. A write flagged as burst keeps write-enable low into the next word, and the byte selects alone mark off consecutive words. Read data is captured on the last wait-state edge and returned with a one-cycle acknowledge.

Top module: `sram_bl_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all RAM strobes are high, the bus output-enable is low, ack is low and rdata is zero.
- R2: A read holds chip-enable and output-enable low and write-enable high for RD_WAIT cycles. In those cycles only the selects of enabled lanes are low (req_be[0] drives sram_bsel_n[0] for bits 7..0, req_be[1] drives sram_bsel_n[1] for bits 15..8). The next cycle has every strobe high and ack high for exactly one cycle.
- R3: rdata takes the bus value sampled at the edge that ends the last read cycle. A lane whose enable bit is 0 returns zero, and rdata holds until the next read completes.
- R4: A write spends WR_SETUP cycles with chip-enable and write-enable low, both selects high and data driven. It then spends WR_PULSE cycles with the selects of enabled lanes low, and then one cycle with both selects high, data still driven and ack high.
- R5: Output-enable stays high during every write cycle, and the bus is never driven while output-enable is low.
- R6: A write whose mask is 00 lowers no byte select and leaves the memory contents unchanged.
- R7: A read taken at the first idle edge after a write first spends TURN_CYC cycles with all strobes high and the bus released.
- R8: A write flagged burst is followed by one link cycle with chip-enable and write-enable still low and both selects high. A write request seen at the end of that cycle starts without write-enable rising. Otherwise write-enable rises in the next cycle.
- R9: A request is taken at the edge that ends an idle cycle (or a link cycle, for a write). The edge that ends an ack cycle takes no request. The host holds its request until ack.
- R10: sram_addr equals the address of the request being served while chip-enable is low, and it does not change while any byte select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Keep write-enable low after this write |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = low byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 17 | RAM address |
| sram_ce_n | output | 1 | RAM chip-enable, active low |
| sram_oe_n | output | 1 | RAM output-enable, active low |
| sram_we_n | output | 1 | RAM write-enable, active low |
| sram_bsel_n | output | 2 | Byte selects, bit 0 = low byte, active low |
| sram_dq_o | output | 16 | Data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | 16 | Data from the RAM |

## Verification
The hardest situations to reach are those that depend on when a request arrives relative to the end of the previous operation. A read that arrives in the ack cycle of a write pays the turnaround, but one that arrives a few cycles later does not. A burst word presented in the link cycle continues the burst, while a read at that point closes it. The bench varies the gap between each ack and the next request from zero to several cycles, across plain writes, chained burst writes and reads. A behavioural RAM in the bench answers only on the strobes that the controller actually raises, so masked writes and the lanes returned on reads are judged on real bus traffic.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_RACK,
    ST_WSET,
    ST_WSTB,
    ST_WHOLD,
    ST_WLINK
  } seq_state_e;
endpackage

// File: rtl/sram_bl_seq.sv
module sram_bl_seq
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int RD_WAIT  = 2,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 1,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              load,
  output logic              cap,
  output logic              win_d,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_oe,
  output logic              ack,
  output logic [ADDR_W-1:0] addr
);
  localparam int MAX_A = (RD_WAIT > WR_SETUP) ? RD_WAIT : WR_SETUP;
  localparam int MAX_B = (WR_PULSE > TURN_CYC) ? WR_PULSE : TURN_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] RD_LAST = CW'(RD_WAIT - 1);
  localparam logic [CW-1:0] WS_LAST = CW'(WR_SETUP - 1);
  localparam logic [CW-1:0] WP_LAST = CW'(WR_PULSE - 1);
  localparam logic [CW-1:0] TN_LAST = CW'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

  seq_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              turn_q, turn_d;
  logic              burst_q, burst_d;
  logic [ADDR_W-1:0] addr_d;
  logic              cnt_end;

  assign cnt_end = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    turn_d  = turn_q;
    burst_d = burst_q;
    load    = 1'b0;
    cap     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        turn_d = 1'b0;
        if (req) begin
          load = 1'b1;
          if (req_we) begin
            state_d = ST_WSET;
            cnt_d   = WS_LAST;
          end else if (turn_q && (TURN_CYC > 0)) begin
            state_d = ST_TURN;
            cnt_d   = TN_LAST;
          end else begin
            state_d = ST_RD;
            cnt_d   = RD_LAST;
          end
        end
      end
      ST_TURN: begin
        if (cnt_end) begin
          state_d = ST_RD;
          cnt_d   = RD_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RD: begin
        if (cnt_end) begin
          cap     = 1'b1;
          state_d = ST_RACK;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RACK: state_d = ST_IDLE;
      ST_WSET: begin
        if (cnt_end) begin
          state_d = ST_WSTB;
          cnt_d   = WP_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WSTB: begin
        if (cnt_end) state_d = ST_WHOLD;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_WHOLD: begin
        if (burst_q) begin
          state_d = ST_WLINK;
        end else begin
          state_d = ST_IDLE;
          turn_d  = 1'b1;
        end
      end
      ST_WLINK: begin
        if (req && req_we) begin
          load    = 1'b1;
          state_d = ST_WSET;
          cnt_d   = WS_LAST;
        end else begin
          state_d = ST_IDLE;
          turn_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (load) burst_d = req_burst;
    addr_d = load ? req_addr : addr;
  end

  logic wr_phase_d;
  assign wr_phase_d = (state_d == ST_WSET) || (state_d == ST_WSTB) ||
                      (state_d == ST_WHOLD) || (state_d == ST_WLINK);
  assign win_d = (state_d == ST_RD) || (state_d == ST_WSTB);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      turn_q  <= 1'b0;
      burst_q <= 1'b0;
      addr    <= '0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      ack     <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      turn_q  <= turn_d;
      burst_q <= burst_d;
      addr    <= addr_d;
      ce_n    <= !((state_d == ST_RD) || wr_phase_d);
      oe_n    <= !(state_d == ST_RD);
      we_n    <= !wr_phase_d;
      dq_oe   <= wr_phase_d;
      ack     <= (state_d == ST_RACK) || (state_d == ST_WHOLD);
    end
  end

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R5
  drive_vs_read_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

  // R7
  oe_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> !$past(dq_oe));
endmodule

// File: rtl/sram_bl_lane.sv
module sram_bl_lane #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          win_d,
  input  logic          cap,
  input  logic          be_in,
  input  logic [LW-1:0] wd_in,
  input  logic [LW-1:0] dq_in,
  output logic          sel_n,
  output logic [LW-1:0] dq_out,
  output logic [LW-1:0] rd_out
);
  logic be_q;
  logic be_d;

  assign be_d = load ? be_in : be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      be_q   <= 1'b0;
      dq_out <= '0;
      rd_out <= '0;
      sel_n  <= 1'b1;
    end else begin
      be_q  <= be_d;
      sel_n <= !(win_d && be_d);
      if (load) dq_out <= wd_in;
      if (cap) rd_out <= be_q ? dq_in : '0;
    end
  end
endmodule

// File: rtl/sram_bl_ctrl.sv
module sram_bl_ctrl
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int RD_WAIT  = 2,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 1,
  parameter int TURN_CYC = 1,
  localparam int LANES   = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [LANES-1:0]  sram_bsel_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  logic take;
  logic capture;
  logic strobe_win;

  sram_bl_seq #(
    .ADDR_W  (ADDR_W),
    .RD_WAIT (RD_WAIT),
    .WR_SETUP(WR_SETUP),
    .WR_PULSE(WR_PULSE),
    .TURN_CYC(TURN_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_we   (req_we),
    .req_burst(req_burst),
    .req_addr (req_addr),
    .load     (take),
    .cap      (capture),
    .win_d    (strobe_win),
    .ce_n     (sram_ce_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .dq_oe    (sram_dq_oe),
    .ack      (ack),
    .addr     (sram_addr)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_bl_lane #(.LW(LANE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .load  (take),
      .win_d (strobe_win),
      .cap   (capture),
      .be_in (req_be[i]),
      .wd_in (req_wdata[i*LANE_W +: LANE_W]),
      .dq_in (sram_dq_i[i*LANE_W +: LANE_W]),
      .sel_n (sram_bsel_n[i]),
      .dq_out(sram_dq_o[i*LANE_W +: LANE_W]),
      .rd_out(rdata[i*LANE_W +: LANE_W])
    );
  end

  // R2
  sel_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !(&sram_bsel_n) |-> !sram_ce_n);

  // R4
  write_strobe_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&sram_bsel_n) && !sram_we_n) |-> sram_dq_oe);

  // R4
  we_fall_sel_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> (&sram_bsel_n));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&sram_bsel_n) && !(&$past(sram_bsel_n))) |-> $stable(sram_addr));
endmodule

// File: tb/sram_bl_ctrl_tb.sv
module sram_bl_ctrl_tb;
  localparam int AW  = 17;
  localparam int DW  = 16;
  localparam int RDW = 2;
  localparam int WS  = 1;
  localparam int WP  = 1;
  localparam int TC  = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          req = 1'b0, req_we = 1'b0, req_burst = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          ack;
  logic [DW-1:0] rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]    sram_bsel_n;
  logic [DW-1:0] sram_dq_o;
  logic [DW-1:0] sram_dq_i = '0;

  sram_bl_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RDW), .WR_SETUP(WS),
                 .WR_PULSE(WP), .TURN_CYC(TC)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_burst(req_burst),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .ack(ack),
    .rdata(rdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_bsel_n(sram_bsel_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i));

  typedef struct {
    logic ce, oe, we;
    logic [1:0] sel;
    logic dqoe, ack, rd;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [DW-1:0] rdv;
    int tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem  [int];
  logic [DW-1:0] sram_mem [int];

  logic          first_op = 1'b1;
  logic          prev_we = 1'b0, prev_bu = 1'b0;
  logic [AW-1:0] prev_a = '0;
  logic [DW-1:0] prev_d = '0;

  function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
  endfunction

  function automatic logic [DW-1:0] sram_rd(input logic [AW-1:0] a);
    return sram_mem.exists(int'(a)) ? sram_mem[int'(a)] : '0;
  endfunction

  task automatic chk(input int r, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h at %0t", r, what, act, expv, $time);
    end
  endtask

  task automatic push(input logic ce, input logic oe, input logic we,
                      input logic [1:0] sel, input logic dqoe, input logic ak,
                      input logic rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [DW-1:0] rdv,
                      input int tag);
    exp_t e;
    e.ce = ce; e.oe = oe; e.we = we; e.sel = sel; e.dqoe = dqoe;
    e.ack = ak; e.rd = rd; e.a = a; e.d = d; e.rdv = rdv; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // per-cycle comparison and behavioural RAM
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        exp_t e;
        if (exp_q.size() > 0) e = exp_q.pop_front();
        else begin
          e.ce = 1; e.oe = 1; e.we = 1; e.sel = 2'b11; e.dqoe = 0; e.ack = 0;
          e.rd = 0; e.a = '0; e.d = '0; e.rdv = '0; e.tag = 9; // R9 idle
        end
        chk(e.tag, "ce_n", sram_ce_n, e.ce);
        chk(e.tag, "oe_n", sram_oe_n, e.oe);
        chk(e.tag, "we_n", sram_we_n, e.we);
        chk(e.tag, "bsel_n", sram_bsel_n, e.sel);
        chk(e.tag, "dq_oe", sram_dq_oe, e.dqoe);
        chk(e.tag, "ack", ack, e.ack);
        if (!e.ce) chk(10, "addr", sram_addr, e.a); // R10
        if (e.dqoe) chk(e.tag, "dq_o", sram_dq_o, e.d);
        if (e.rd) chk(3, "rdata", rdata, e.rdv); // R3
        // RAM model: write on overlap of strobes, read drive per lane
        if (!sram_ce_n && !sram_we_n && sram_dq_oe && !(&sram_bsel_n)) begin
          logic [DW-1:0] w;
          w = sram_rd(sram_addr);
          if (!sram_bsel_n[0]) w[7:0]  = sram_dq_o[7:0];
          if (!sram_bsel_n[1]) w[15:8] = sram_dq_o[15:8];
          sram_mem[int'(sram_addr)] = w;
        end
        begin
          logic [DW-1:0] r;
          logic rd_on;
          r = sram_rd(sram_addr);
          rd_on = !sram_ce_n && !sram_oe_n && sram_we_n;
          sram_dq_i[7:0]  = (rd_on && !sram_bsel_n[0]) ? r[7:0]  : 8'hA5;
          sram_dq_i[15:8] = (rd_on && !sram_bsel_n[1]) ? r[15:8] : 8'h5A;
        end
      end
    end
  end

  task automatic op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [1:0] be, input logic bu, input int g);
    int nidle;
    logic turn;
    nidle = 0;
    turn = 1'b0;
    if (!first_op) begin
      do begin @(negedge clk); #1; end while (exp_q.size() != 0);
      if (prev_we && prev_bu) begin
        push(0, 1, 0, 2'b11, 1, 0, 0, prev_a, prev_d, '0, 8); // R8 link
        if (we && g <= 1) nidle = 0;
        else begin
          nidle = ((g > 2) ? g : 2) - 1;
          turn = (g <= 2);
        end
      end else begin
        nidle = (g > 1) ? g : 1;
        turn = prev_we && (g <= 1);
      end
    end
    for (int i = 0; i < nidle; i++)
      push(1, 1, 1, 2'b11, 0, 0, 0, '0, '0, '0, 9); // R9
    if (we) begin
      logic [DW-1:0] m;
      for (int i = 0; i < WS; i++) push(0, 1, 0, 2'b11, 1, 0, 0, a, d, '0, 4); // R4
      for (int i = 0; i < WP; i++)
        push(0, 1, 0, ~be, 1, 0, 0, a, d, '0, (be == 2'b00) ? 6 : 4); // R6 / R4
      push(0, 1, 0, 2'b11, 1, 1, 0, a, d, '0, 4); // R4 hold + ack
      m = ref_rd(a);
      if (be[0]) m[7:0]  = d[7:0];
      if (be[1]) m[15:8] = d[15:8];
      ref_mem[int'(a)] = m;
    end else begin
      logic [DW-1:0] rv;
      rv = ref_rd(a);
      if (!be[0]) rv[7:0]  = 8'h00;
      if (!be[1]) rv[15:8] = 8'h00;
      if (turn) for (int i = 0; i < TC; i++)
        push(1, 1, 1, 2'b11, 0, 0, 0, '0, '0, '0, 7); // R7
      for (int i = 0; i < RDW; i++) push(0, 0, 1, ~be, 0, 0, 0, a, '0, '0, 2); // R2
      push(1, 1, 1, 2'b11, 0, 1, 1, '0, '0, rv, 2); // R2 ack, R3 data
    end
    if (!first_op && g > 0) begin
      req = 1'b0;
      repeat (g) begin @(negedge clk); #1; end
    end
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be; req_burst = bu;
    prev_we = we; prev_bu = bu; prev_a = a; prev_d = d;
    first_op = 1'b0;
  endtask

  task automatic drain();
    do begin @(negedge clk); #1; end while (exp_q.size() != 0);
    if (prev_we && prev_bu) push(0, 1, 0, 2'b11, 1, 0, 0, prev_a, prev_d, '0, 8); // R8 ends
    req = 1'b0;
    repeat (5) begin @(negedge clk); #1; end
    first_op = 1'b1;
    prev_we = 1'b0; prev_bu = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "ce_n", sram_ce_n, 1); chk(1, "oe_n", sram_oe_n, 1);
    chk(1, "we_n", sram_we_n, 1); chk(1, "bsel_n", sram_bsel_n, 2'b11);
    chk(1, "dq_oe", sram_dq_oe, 0); chk(1, "ack", ack, 0);
    chk(1, "rdata", rdata, 0);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    op(1, 17'h00010, 16'hBEEF, 2'b11, 0, 0);  // R4 full write
    op(0, 17'h00010, 16'h0000, 2'b11, 0, 0);  // R7 turnaround, R2, R3
    op(0, 17'h00010, 16'h0000, 2'b01, 0, 3);  // R3 low lane only
    op(1, 17'h00010, 16'h12AA, 2'b10, 0, 2);  // R4 upper lane only
    op(0, 17'h00010, 16'h0000, 2'b11, 0, 1);  // R7 gap of one still turns
    op(1, 17'h1FFFF, 16'hC3C3, 2'b11, 0, 4);  // R10 top address
    op(1, 17'h00100, 16'h1111, 2'b11, 1, 2);  // R8 burst start
    op(1, 17'h00101, 16'h2222, 2'b01, 1, 0);  // R8 continue in ack cycle
    op(1, 17'h00102, 16'h3333, 2'b11, 1, 1);  // R8 continue in link cycle
    op(0, 17'h00100, 16'h0000, 2'b11, 0, 0);  // R8 closed by read, R7
    op(0, 17'h00101, 16'h0000, 2'b11, 0, 0);  // R3
    op(1, 17'h00040, 16'h5555, 2'b00, 0, 0);  // R6 empty mask
    op(0, 17'h00040, 16'h0000, 2'b11, 0, 2);  // R6 memory unchanged
    op(0, 17'h1FFFF, 16'h0000, 2'b10, 0, 0);  // R3 upper lane
    op(0, 17'h00102, 16'h0000, 2'b00, 0, 1);  // R3 no lanes
    op(1, 17'h00200, 16'hABCD, 2'b11, 1, 3);  // R8 burst with no follower
    drain();
    op(0, 17'h00200, 16'h0000, 2'b11, 0, 0);  // R9 steady idle, no turn
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule